// File: doc/BRIEF.md
# CRC Syndrome and Column Generator

This block sits behind a soft-output channel decoder. It takes one received CRC packet as a stream of log-likelihood samples and slices each sample to a hard bit. It then accumulates the full m-bit syndrome of the packet against one of four selectable generator polynomials. A correction stage further down the line needs more than a pass/fail flag. It needs the complete syndrome vector and the parity-matrix column of any bit position, so the block also answers position queries with the remainder of x^pos divided by the generator.

A packet begins with a `start` pulse. Its bits then arrive in index order, starting at index 0. The m parity bits come first and the information bits follow. The last bit is flagged with `in_last`. One cycle later the syndrome is valid, and it stays valid until the next packet starts. The query port runs separately. It computes each column by stepping the shift-and-reduce recurrence from x^0, so a query for position pos takes pos+1 cycles.

Top module: `crc_syn_top`

## Requirements
- R1: A sample counts as hard bit 1 only when its signed LLR is strictly greater than zero. A zero or negative sample counts as bit 0.
- R2: `poly_sel` encodes 0 = x^12+x^11+x^3+x^2+x+1, 1 = x^24+x^23+x^14+x^12+x^8+1, 2 = x^12+1 and 3 = x^24+1. The value is sampled when `start` is sampled (syndrome path) or when `q_req` is sampled (query path). For 12-bit generators, bits 23..12 of `syndrome` and `q_col` read 0.
- R3: After a query, `q_col` equals the coefficient vector of rem(x^pos, g), with bit j holding the x^j coefficient. For pos < m this is the one-hot vector with bit pos set, and it is never zero.
- R4: `q_done` is high for exactly one cycle, pos+1 clock edges after the edge that samples `q_req`. `q_col` holds its value until the next `q_done`. A new `q_req` while a query is running abandons the old one and starts over.
- R5: `syndrome` is the GF(2) sum of the columns of all positions whose hard bit is 1, with the first accepted bit at position 0. A packet laid out as remainder bits followed by message bits, with r = rem(x^m·b, g), gives a zero syndrome.
- R6: On the cycle after the edge that accepts a bit with `in_last` high, `syn_ready` is 1 and exactly one of `chk_pass` (syndrome zero) or `chk_fail` (syndrome nonzero) is 1.
- R7: Once the syndrome is ready, `syndrome`, `syn_ready`, `chk_pass` and `chk_fail` hold until the next `start`. `in_valid` has no effect outside a packet, whether before the first `start` or after the last bit.
- R8: The cycle after `start` is sampled, the syndrome reads zero and `syn_ready`, `chk_pass` and `chk_fail` are all 0. A sample presented in the same cycle as `start` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new packet and samples `poly_sel` |
| poly_sel | input | 2 | Generator choice (encoding in R2) |
| in_valid | input | 1 | An LLR sample is present |
| in_last | input | 1 | Present sample is the final bit of the packet |
| in_llr | input | LLR_W | Signed soft value of the current bit |
| q_req | input | 1 | Starts a column query, samples `q_pos` and `poly_sel` |
| q_pos | input | POS_W | Bit position being queried |
| q_done | output | 1 | One-cycle strobe: `q_col` is updated |
| q_col | output | 24 | Parity-matrix column of the queried position |
| syn_ready | output | 1 | Syndrome of the current packet is complete |
| chk_pass | output | 1 | Completed syndrome is zero |
| chk_fail | output | 1 | Completed syndrome is nonzero |
| syndrome | output | 24 | Accumulated syndrome vector |

## Verification
The properties assume that `start` separates packets and that `in_last` comes with a valid sample inside a packet. They also assume `q_pos` is stable on the cycle `q_req` is sampled. The stimulus meets these assumptions by driving every input on the falling edge, one transaction at a time, with each input pulse lasting exactly one cycle. The bench does deliberately send samples outside a packet and a sample together with `start`. For these cases the properties only require that the outputs hold or clear, and these cases check exactly that. Expected columns and syndromes come from polynomial long division over the whole packet in the bench, not from the shift recurrence the design uses.

// File: rtl/crc_syn_pkg.sv
package crc_syn_pkg;

    localparam int MW = 24;

    typedef logic [MW-1:0] col_t;

    typedef enum logic [1:0] {
        SEL_CRC12 = 2'd0,
        SEL_CRC24 = 2'd1,
        SEL_PAR12 = 2'd2,
        SEL_PAR24 = 2'd3
    } poly_sel_e;

    // taps: generator coefficients below x^m; mask: the m live bits;
    // msb: one-hot marker of bit m-1, whose carry triggers reduction
    typedef struct packed {
        col_t taps;
        col_t mask;
        col_t msb;
    } poly_cfg_t;

    localparam col_t COL_ONE = col_t'(1);

    function automatic poly_cfg_t poly_decode(input poly_sel_e sel);
        poly_cfg_t p;
        case (sel)
            SEL_CRC12: begin p.taps = 24'h00080F; p.mask = 24'h000FFF; p.msb = 24'h000800; end
            SEL_CRC24: begin p.taps = 24'h805101; p.mask = 24'hFFFFFF; p.msb = 24'h800000; end
            SEL_PAR12: begin p.taps = 24'h000001; p.mask = 24'h000FFF; p.msb = 24'h000800; end
            default:   begin p.taps = 24'h000001; p.mask = 24'hFFFFFF; p.msb = 24'h800000; end
        endcase
        return p;
    endfunction

    // rem(x^(i+1), g) from rem(x^i, g)
    function automatic col_t col_advance(input col_t c, input poly_cfg_t p);
        logic carry;
        col_t nxt;
        carry = |(c & p.msb);
        nxt   = (c << 1) & p.mask;
        if (carry) nxt = nxt ^ p.taps;
        return nxt;
    endfunction

endpackage

// File: rtl/crc_hard_slice.sv
module crc_hard_slice #(
    parameter int LLR_W = 6
) (
    input  logic signed [LLR_W-1:0] llr_i,
    output logic                    bit_o
);
    localparam logic signed [LLR_W-1:0] ZERO = '0;

    always_comb begin
        bit_o = (llr_i > ZERO);
    end
endmodule

// File: rtl/crc_syn_accum.sv
module crc_syn_accum
    import crc_syn_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  poly_cfg_t cfg_in,
    input  logic      bit_valid,
    input  logic      bit_val,
    input  logic      bit_last,
    output col_t      syn_o,
    output logic      ready_o,
    output logic      pass_o,
    output logic      fail_o
);
    logic      active_q;
    poly_cfg_t cfg_q;
    col_t      col_q;
    col_t      syn_q;
    col_t      syn_next;
    logic      ready_q, pass_q, fail_q;

    always_comb begin
        syn_next = syn_q ^ (bit_val ? col_q : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cfg_q    <= '0;
            col_q    <= COL_ONE;
            syn_q    <= '0;
            ready_q  <= 1'b0;
            pass_q   <= 1'b0;
            fail_q   <= 1'b0;
        end else if (start) begin
            active_q <= 1'b1;
            cfg_q    <= cfg_in;
            col_q    <= COL_ONE;
            syn_q    <= '0;
            ready_q  <= 1'b0;
            pass_q   <= 1'b0;
            fail_q   <= 1'b0;
        end else if (active_q && bit_valid) begin
            syn_q <= syn_next;
            col_q <= col_advance(col_q, cfg_q);
            if (bit_last) begin
                active_q <= 1'b0;
                ready_q  <= 1'b1;
                pass_q   <= (syn_next == '0);
                fail_q   <= (syn_next != '0);
            end
        end
    end

    assign syn_o   = syn_q;
    assign ready_o = ready_q;
    assign pass_o  = pass_q;
    assign fail_o  = fail_q;
endmodule

// File: rtl/crc_col_query.sv
module crc_col_query
    import crc_syn_pkg::*;
#(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [POS_W-1:0] pos,
    input  poly_cfg_t        cfg_in,
    output logic             done_o,
    output col_t             col_o
);
    logic             busy_q;
    logic [POS_W-1:0] cnt_q;
    poly_cfg_t        cfg_q;
    col_t             walk_q;
    col_t             res_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            cfg_q  <= '0;
            walk_q <= COL_ONE;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (req) begin
                busy_q <= 1'b1;
                cnt_q  <= pos;
                cfg_q  <= cfg_in;
                walk_q <= COL_ONE;
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    res_q  <= walk_q;
                end else begin
                    cnt_q  <= cnt_q - 1'b1;
                    walk_q <= col_advance(walk_q, cfg_q);
                end
            end
        end
    end

    assign done_o = done_q;
    assign col_o  = res_q;
endmodule

// File: rtl/crc_syn_top.sv
module crc_syn_top
    import crc_syn_pkg::*;
#(
    parameter int LLR_W = 6,
    parameter int POS_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [1:0]              poly_sel,
    input  logic                    in_valid,
    input  logic                    in_last,
    input  logic signed [LLR_W-1:0] in_llr,
    input  logic                    q_req,
    input  logic [POS_W-1:0]        q_pos,
    output logic                    q_done,
    output logic [MW-1:0]           q_col,
    output logic                    syn_ready,
    output logic                    chk_pass,
    output logic                    chk_fail,
    output logic [MW-1:0]           syndrome
);
    poly_cfg_t sel_cfg;
    logic      hard_bit;

    always_comb begin
        sel_cfg = poly_decode(poly_sel_e'(poly_sel));
    end

    crc_hard_slice #(.LLR_W(LLR_W)) u_slice (
        .llr_i (in_llr),
        .bit_o (hard_bit)
    );

    crc_syn_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_in    (sel_cfg),
        .bit_valid (in_valid),
        .bit_val   (hard_bit),
        .bit_last  (in_last),
        .syn_o     (syndrome),
        .ready_o   (syn_ready),
        .pass_o    (chk_pass),
        .fail_o    (chk_fail)
    );

    crc_col_query #(.POS_W(POS_W)) u_query (
        .clk    (clk),
        .rst    (rst),
        .req    (q_req),
        .pos    (q_pos),
        .cfg_in (sel_cfg),
        .done_o (q_done),
        .col_o  (q_col)
    );
endmodule

// File: rtl/crc_syn_chk.sv
module crc_syn_chk #(
    parameter int MW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          in_valid,
    input logic          in_last,
    input logic          q_done,
    input logic [MW-1:0] q_col,
    input logic          syn_ready,
    input logic          chk_pass,
    input logic          chk_fail,
    input logic [MW-1:0] syndrome
);
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(chk_pass && chk_fail));

    a_r6_pass_zero: assert property (@(posedge clk) disable iff (rst)
        chk_pass |-> (syndrome == '0) && syn_ready);

    a_r6_fail_nonzero: assert property (@(posedge clk) disable iff (rst)
        chk_fail |-> (syndrome != '0) && syn_ready);

    a_r6_ready_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(syn_ready) |-> $past(in_valid && in_last));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (syn_ready && !start) |=> syn_ready && $stable(syndrome) && $stable(chk_pass));

    a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> !syn_ready && !chk_pass && !chk_fail && (syndrome == '0));

    a_r3_col_nonzero: assert property (@(posedge clk) disable iff (rst)
        q_done |-> (q_col != '0));

    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        q_done |=> !q_done);
endmodule

bind crc_syn_top crc_syn_chk #(.MW(crc_syn_pkg::MW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .q_done    (q_done),
    .q_col     (q_col),
    .syn_ready (syn_ready),
    .chk_pass  (chk_pass),
    .chk_fail  (chk_fail),
    .syndrome  (syndrome)
);

// File: tb/sim_crc_syn_top.sv
module sim_crc_syn_top;
    localparam int LLR_W = 6;
    localparam int POS_W = 10;
    localparam int K     = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] poly_sel = 2'd0;
    logic in_valid = 1'b0;
    logic in_last = 1'b0;
    logic signed [LLR_W-1:0] in_llr = '0;
    logic q_req = 1'b0;
    logic [POS_W-1:0] q_pos = '0;
    logic q_done, syn_ready, chk_pass, chk_fail;
    logic [23:0] q_col, syndrome;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    crc_syn_top #(.LLR_W(LLR_W), .POS_W(POS_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .poly_sel(poly_sel),
        .in_valid(in_valid), .in_last(in_last), .in_llr(in_llr),
        .q_req(q_req), .q_pos(q_pos), .q_done(q_done), .q_col(q_col),
        .syn_ready(syn_ready), .chk_pass(chk_pass), .chk_fail(chk_fail),
        .syndrome(syndrome)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog: run hung, actual=%0d expected<190000 cycles", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [24:0] gen_of(input int sel);
        case (sel)
            0: return 25'h000180F;
            1: return 25'h1805101;
            2: return 25'h0001001;
            default: return 25'h1000001;
        endcase
    endfunction

    function automatic int m_of(input int sel);
        return (sel == 0 || sel == 2) ? 12 : 24;
    endfunction

    // long division of polynomial a (degree <= top) by g of degree m
    function automatic logic [23:0] rem_poly(input logic [1023:0] a, input int top,
                                             input int m, input logic [24:0] g);
        for (int d = top; d >= m; d--)
            if (a[d])
                for (int t = 0; t <= m; t++) a[d-m+t] = a[d-m+t] ^ g[t];
        return a[23:0];
    endfunction

    function automatic logic [23:0] col_of(input int sel, input int pos);
        logic [1023:0] a;
        a = '0;
        a[pos] = 1'b1;
        return rem_poly(a, pos, m_of(sel), gen_of(sel));
    endfunction

    task automatic pulse_start(input int sel, input bit with_sample);
        @(negedge clk);
        start = 1'b1;
        poly_sel = 2'(sel);
        in_valid = with_sample;
        in_llr = with_sample ? 6'sd17 : 6'sd0;
        @(negedge clk);
        start = 1'b0;
        in_valid = 1'b0;
        poly_sel = 2'(~sel);
        // R8: cleared state right after start
        check(!syn_ready && !chk_pass && !chk_fail && syndrome == 0, "R8 start clears",
              {syn_ready, chk_pass, chk_fail, syndrome}, 0);
    endtask

    task automatic send_sample(input int v, input bit last);
        in_valid = 1'b1;
        in_last = last;
        in_llr = LLR_W'(v);
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    // flip_a/flip_b: bit errors; zero_pos: a bit sent with LLR exactly 0
    task automatic run_packet(input int sel, input int flip_a, input int flip_b,
                              input int zero_pos, input bit sample_with_start, input string tag);
        logic [1023:0] a, eff;
        logic [23:0] r, exp_syn;
        int m, n, v;
        m = m_of(sel);
        n = m + K;
        a = '0;
        for (int j = 0; j < K; j++) a[m+j] = 1'($urandom);
        r = rem_poly(a, n - 1, m, gen_of(sel));
        eff = a;
        for (int i = 0; i < m; i++) eff[i] = r[i];
        if (flip_a >= 0) eff[flip_a] = ~eff[flip_a];
        if (flip_b >= 0) eff[flip_b] = ~eff[flip_b];
        if (zero_pos >= 0) eff[zero_pos] = 1'b0;
        exp_syn = rem_poly(eff, n - 1, m, gen_of(sel));
        pulse_start(sel, sample_with_start);
        for (int i = 0; i < n; i++) begin
            if (eff[i]) v = 1 + int'($urandom % 31);
            else if (i == zero_pos) v = 0;
            else if ($urandom % 3 == 0) v = 0;
            else v = -(1 + int'($urandom % 32));
            send_sample(v, i == n - 1);
        end
        check(syn_ready == 1'b1, {tag, " R6 ready"}, syn_ready, 1);
        check(syndrome == exp_syn, {tag, " R5 syndrome"}, syndrome, exp_syn);
        check(chk_pass == (exp_syn == 0) && chk_fail == (exp_syn != 0), {tag, " R6 flags"},
              {chk_pass, chk_fail}, {exp_syn == 0, exp_syn != 0});
    endtask

    task automatic run_query(input int sel, input int pos);
        int cyc;
        logic [23:0] exp_col;
        exp_col = col_of(sel, pos);
        @(negedge clk);
        poly_sel = 2'(sel);
        q_pos = POS_W'(pos);
        q_req = 1'b1;
        @(negedge clk);
        q_req = 1'b0;
        poly_sel = 2'(~sel);
        cyc = 1;
        while (!q_done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == pos + 2, "R4 latency", cyc, pos + 2);
        check(q_col == exp_col, "R3 R2 column", q_col, exp_col);
        if (pos < m_of(sel))
            check(q_col == (24'd1 << pos), "R3 identity block", q_col, 24'd1 << pos);
    endtask

    initial begin
        logic [23:0] held;
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!syn_ready && !chk_pass && !chk_fail && !q_done && syndrome == 0,
              "R7 reset state", {syn_ready, chk_pass, chk_fail, q_done}, 0);
        // R7: samples before any start are ignored
        send_sample(20, 1'b1);
        check(!syn_ready && syndrome == 0, "R7 no packet", {syn_ready, syndrome}, 0);

        // column sweep, every generator
        for (int sel = 0; sel < 4; sel++) begin
            for (int p = 0; p < m_of(sel) + 40; p++) run_query(sel, p);
            run_query(sel, 300);
            run_query(sel, 1023);
        end

        // R4: restart while busy
        @(negedge clk);
        poly_sel = 2'd1; q_pos = 10'd50; q_req = 1'b1;
        @(negedge clk);
        q_req = 1'b0;
        repeat (3) @(negedge clk);
        q_pos = 10'd30; q_req = 1'b1;
        @(negedge clk);
        q_req = 1'b0;
        cyc = 1;
        while (!q_done && cyc < 2000) begin @(negedge clk); cyc++; end
        check(cyc == 32, "R4 restart latency", cyc, 32);
        check(q_col == col_of(1, 30), "R4 restart column", q_col, col_of(1, 30));
        held = q_col;
        repeat (5) @(negedge clk);
        check(q_col == held && !q_done, "R4 column held", q_col, held);

        // syndrome packets
        for (int sel = 0; sel < 4; sel++) begin
            int n;
            n = m_of(sel) + K;
            for (int rep = 0; rep < 3; rep++) run_packet(sel, -1, -1, -1, 1'b0, "clean");
            run_packet(sel, 0, -1, -1, 1'b0, "err0");
            run_packet(sel, m_of(sel) - 1, -1, -1, 1'b0, "errpar");
            run_packet(sel, n - 1, -1, -1, 1'b0, "errlast");
            run_packet(sel, 3, m_of(sel) + 5, -1, 1'b0, "err2");
            run_packet(sel, -1, -1, m_of(sel) + 2, 1'b0, "R1 zero llr");
            run_packet(sel, -1, -1, -1, 1'b1, "R8 sample at start");
            // R7: samples after the last bit are ignored
            held = syndrome;
            send_sample(25, 1'b0);
            send_sample(9, 1'b1);
            check(syn_ready && syndrome == held, "R7 ignore after last", syndrome, held);
        end

        // R1: single-bit packets isolate the slicer
        for (int v = -32; v < 32; v += 1) begin
            pulse_start(1, 1'b0);
            send_sample(v, 1'b1);
            check(syndrome == ((v > 0) ? 24'd1 : 24'd0), "R1 slice",
                  syndrome, (v > 0) ? 1 : 0);
        end

        summary();
        $finish;
    end
endmodule